// File: doc/BRIEF.md
# Unaligned Partial Store Lane Generator

This block converts one left or right partial store, word or doubleword, into a single aligned write beat on an eight-byte memory bus. It takes the store's effective address, the source register value and the operation kind. From these it works out which bus byte lanes the store touches, and it steers the matching register bytes into those lanes. Software uses a pair of such stores, one left and one right, to write a value at an address that is not aligned.

The byte order of the core is fixed when the block is built. On the bus, lane k always carries the byte at address (aligned address + k), whatever the byte order. The byte order only changes which end of the aligned unit a store fills and which register byte lands in each lane.

A request is accepted by a two-state machine. `ST_IDLE` is the only state that accepts a request, and the transition taken on acceptance is "capture". In `ST_HOLD` the beat is presented to memory. The transition "release" is taken when the memory ready is sampled high and returns the machine to `ST_IDLE`. While the machine waits in `ST_HOLD` with ready low, the transition is "wait", which stays in the same state.

Top module: `ulst_store_lanes`

## Requirements
- R1: The operation code is encoded as follows: bit 1 = 1 selects a doubleword and 0 selects a word, and bit 0 = 1 selects a right store and 0 selects a left store.
- R1 (continued): The lane index is the low address bits within the unit (2 bits for a word, 3 for a doubleword) when big-endian. When little-endian, the lane index is those bits XORed with 3 (word) or 7 (doubleword).
- R2: A left store puts the most significant operand byte (byte 3 for a word, byte 7 for a doubleword) at the effective address. It then places successively lower operand bytes at successive further addresses, writing (unit size − lane index) bytes in total.
- R3: A right store puts operand byte 0 at the effective address. It then places successively higher operand bytes at successive further addresses, writing (lane index + 1) bytes in total.
- R4: On big-endian builds the further addresses of a left store ascend. On little-endian builds they descend. A right store steps in the opposite direction to the left store of the same build.
- R5: A doubleword left store with lane index 0, or a doubleword right store with lane index 7, asserts all eight strobes.
- R6: A lane whose strobe is low carries zero data.
- R7: A word store uses operand bits 31:0 only. Its strobes stay inside the 4-byte half of the bus that holds the effective address.
- R8: The output address is the effective address with bits 2:0 cleared.
- R9: While a beat is pending and ready is low, the valid, address, data and strobes stay unchanged. During that time request ready is low, and any request presented is ignored.
- R10: After reset no beat is valid and request ready is high.
- R11: In the cycle after ready is sampled high with a beat valid, the beat valid is low and request ready is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Operation: bit1 doubleword, bit0 right |
| req_addr | input | ADDR_W | Effective byte address |
| req_data | input | 64 | Source register value |
| mem_valid | output | 1 | Write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | ADDR_W | Aligned beat address |
| mem_wdata | output | 64 | Lane-ordered write data |
| mem_strb | output | 8 | Per-lane byte enables |

## Verification
On every cycle, the embedded properties check the following: the hold-and-stall contract of the beat, the release timing, the alignment of the output address, that masked lanes carry zero data, the word-half confinement, and the full-width doubleword cases. Which operand byte lands in which lane, and how many lanes open for each offset, is shown only by the bench. The bench sweeps every operation over all eight offsets on a big-endian and a little-endian instance and compares against an address-walking model. A stall scenario with a competing request shows that the beat is not disturbed.

// File: rtl/ulst_pkg.sv
package ulst_pkg;
    typedef enum logic [1:0] {
        OP_WORD_LEFT   = 2'b00,
        OP_WORD_RIGHT  = 2'b01,
        OP_DWORD_LEFT  = 2'b10,
        OP_DWORD_RIGHT = 2'b11
    } ulst_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } beat_state_e;
endpackage

// File: rtl/ulst_lane_map.sv
module ulst_lane_map #(
    parameter int LANES      = 8,
    parameter bit BIG_ENDIAN = 1'b1,
    localparam int OFS_W     = $clog2(LANES)
) (
    input  logic [1:0]         op,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [8*LANES-1:0] src,
    output logic [8*LANES-1:0] lane_data,
    output logic [LANES-1:0]   lane_strb
);
    logic is_dw;
    logic is_right;

    assign is_dw    = op[1];
    assign is_right = op[0];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic             hit;
        logic [OFS_W-1:0] sel;

        always_comb begin
            int  sz;
            int  base;
            int  b;
            int  w;
            int  idx;
            logic upper;
            sz    = is_dw ? LANES : LANES / 2;
            base  = (!is_dw && ofs[OFS_W-1]) ? LANES / 2 : 0;
            b     = int'(ofs) & (sz - 1);
            w     = k - base;
            // upper: the store fills from the offset toward the top of its unit
            upper = (BIG_ENDIAN == !is_right);
            hit   = (w >= 0) && (w < sz) && (upper ? (w >= b) : (w <= b));
            if (!is_right)
                idx = upper ? (sz - 1 - w + b) : (sz - 1 - b + w);
            else
                idx = upper ? (w - b) : (b - w);
            sel = hit ? OFS_W'(idx) : '0;
        end

        assign lane_strb[k]         = hit;
        assign lane_data[8*k +: 8]  = hit ? src[8*sel +: 8] : 8'h00;
    end
endmodule

// File: rtl/ulst_beat_fsm.sv
module ulst_beat_fsm
    import ulst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [8*LANES-1:0]  in_data,
    input  logic [LANES-1:0]    in_strb,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [8*LANES-1:0]  mem_wdata,
    output logic [LANES-1:0]    mem_strb
);
    beat_state_e state_q, state_d;
    logic        capture;

    logic [ADDR_W-1:0]  addr_q;
    logic [8*LANES-1:0] data_q;
    logic [LANES-1:0]   strb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                capture = 1'b1;
                state_d = ST_HOLD;
            end
            ST_HOLD: if (mem_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            strb_q <= '0;
        end else if (capture) begin
            addr_q <= in_addr;
            data_q <= in_data;
            strb_q <= in_strb;
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_valid = (state_q == ST_HOLD);
        mem_addr  = addr_q;
        mem_wdata = data_q;
        mem_strb  = strb_q;
    end

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                 && $stable(mem_wdata) && $stable(mem_strb));
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);
    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid && req_ready);
endmodule

// File: rtl/ulst_store_lanes.sv
module ulst_store_lanes
    import ulst_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    output logic [7:0]        mem_strb
);
    localparam int LANES = 8;
    localparam int OFS_W = $clog2(LANES);

    logic [ADDR_W-1:0]  aligned_addr;
    logic [8*LANES-1:0] steered_data;
    logic [LANES-1:0]   steered_strb;

    assign aligned_addr = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

    ulst_lane_map #(.LANES(LANES), .BIG_ENDIAN(BIG_ENDIAN)) u_map (
        .op        (req_op),
        .ofs       (req_addr[OFS_W-1:0]),
        .src       (req_data),
        .lane_data (steered_data),
        .lane_strb (steered_strb)
    );

    ulst_beat_fsm #(.ADDR_W(ADDR_W), .LANES(LANES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .in_addr   (aligned_addr),
        .in_data   (steered_data),
        .in_strb   (steered_strb),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_strb  (mem_strb)
    );

    logic       fire;
    logic [2:0] dw_lane_idx;
    assign fire        = req_valid && req_ready;
    assign dw_lane_idx = BIG_ENDIAN ? req_addr[2:0] : (req_addr[2:0] ^ 3'd7);

    p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[OFS_W-1:0] == '0);
    p_full_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire && ((req_op == OP_DWORD_LEFT && dw_lane_idx == 3'd0) ||
                 (req_op == OP_DWORD_RIGHT && dw_lane_idx == 3'd7))
        |=> mem_strb == 8'hFF);
    p_word_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !req_op[1] |=> (mem_strb[7:4] == 4'h0) || (mem_strb[3:0] == 4'h0));
    p_some_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_strb != '0);

    for (genvar k = 0; k < LANES; k++) begin : g_zero_chk
        p_zero_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid && !mem_strb[k] |-> mem_wdata[8*k +: 8] == 8'h00);
    end
endmodule

// File: tb/tb_ulst_store_lanes.sv
module tb_ulst_store_lanes;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic        mem_ready = 1'b0;

    logic        rdy_be, rdy_le, val_be, val_le;
    logic [31:0] addr_be, addr_le;
    logic [63:0] dat_be, dat_le;
    logic [7:0]  stb_be, stb_le;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ulst_store_lanes #(.ADDR_W(32), .BIG_ENDIAN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_be),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .mem_valid(val_be), .mem_ready(mem_ready), .mem_addr(addr_be),
        .mem_wdata(dat_be), .mem_strb(stb_be));

    ulst_store_lanes #(.ADDR_W(32), .BIG_ENDIAN(1'b0)) dut_le (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_le),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .mem_valid(val_le), .mem_ready(mem_ready), .mem_addr(addr_le),
        .mem_wdata(dat_le), .mem_strb(stb_le));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model: walk addresses from the effective address, one byte per step.
    task automatic model(input bit be, input logic [1:0] op, input logic [31:0] ea,
                         input logic [63:0] src, output logic [63:0] d, output logic [7:0] s);
        int sz, b, base, lidx, cnt, off, byt;
        sz   = op[1] ? 8 : 4;
        b    = int'(ea[2:0]) & (sz - 1);
        base = op[1] ? 0 : (ea[2] ? 4 : 0);
        lidx = be ? b : (b ^ (sz - 1));                      // R1
        cnt  = op[0] ? lidx + 1 : sz - lidx;                  // R2 R3
        d = '0; s = '0;
        for (int i = 0; i < cnt; i++) begin
            if (!op[0]) begin
                off = be ? b + i : b - i;                     // R4 left
                byt = sz - 1 - i;
            end else begin
                off = be ? b - i : b + i;                     // R4 right
                byt = i;
            end
            s[base + off] = 1'b1;
            d[8*(base + off) +: 8] = src[8*byt +: 8];
        end
    endtask

    task automatic run_one(input logic [1:0] op, input logic [31:0] ea, input logic [63:0] src);
        logic [63:0] ed; logic [7:0] es;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = ea; req_data = src;
        @(negedge clk);
        req_valid = 1'b0;
        model(1'b1, op, ea, src, ed, es);
        chk("R2 R3 R4 R6 R7 be data", dat_be, ed);
        chk("R1 R5 R7 be strb", {56'h0, stb_be}, {56'h0, es});
        model(1'b0, op, ea, src, ed, es);
        chk("R2 R3 R4 R6 R7 le data", dat_le, ed);
        chk("R1 R5 R7 le strb", {56'h0, stb_le}, {56'h0, es});
        chk("R8 address", {addr_be, addr_le}, {ea & 32'hFFFF_FFF8, ea & 32'hFFFF_FFF8});
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R11 release", {62'h0, val_be | val_le, rdy_be & rdy_le}, 64'h1);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] pats [3];
        logic [63:0] held_d; logic [7:0] held_s;
        pats[0] = 64'h8877_6655_4433_2211;
        pats[1] = 64'hF1E2_D3C4_B5A6_9788;
        pats[2] = 64'h0123_4567_89AB_CDEF;
        repeat (3) @(negedge clk);
        chk("R10 reset", {62'h0, val_be | val_le, rdy_be & rdy_le}, 64'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset", {62'h0, val_be | val_le, rdy_be & rdy_le}, 64'h1);

        for (int op = 0; op < 4; op++)
            for (int o = 0; o < 8; o++)
                for (int p = 0; p < 3; p++)
                    run_one(2'(op), 32'h1000_0040 + 32'(o) + 32'(p * 256), pats[p]);

        // R9 stall with a competing request
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b10; req_addr = 32'h2000_0003; req_data = pats[0];
        @(negedge clk);
        req_op = 2'b01; req_addr = 32'h3000_0005; req_data = pats[1];
        held_d = dat_be; held_s = stb_be;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R9 held data", dat_be, held_d);
            chk("R9 held strb", {56'h0, stb_be}, {56'h0, held_s});
            chk("R9 held addr/ready", {addr_be, 30'h0, val_be, rdy_be}, {32'h2000_0000, 32'h2});
        end
        req_valid = 1'b0;
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R11 release after stall", {62'h0, val_be, rdy_be}, 64'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule